// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns a single PWM command into two gate enables for a synchronous buck stage: one for the high-side switch and one for the low-side switch. The two enables are never on together. Every change of PWM passes through a dead-time wait in which both switches are off. All timing is counted in clock cycles. The block samples two comparator results that arrive already digitized. One is true when the switch node is below a low threshold of about 1 V. The other is true when the low-side gate has fallen below one sixth of its supply.

After PWM falls, the high side is switched off at once. The low side then waits for the switch node. If the node was seen high and then falls below the threshold, the low side turns on. If the node was never seen high, a fixed fallback delay applies. If the node stays high too long, a timeout turns the low side on anyway.

After PWM rises, the low side is switched off at once. The high side waits until the low-side gate feedback reports a low gate, and then adds a short fixed delay. An active-low output-enable input forces both switches off and parks the controller in an idle state.

Top module: `deadtime_gate_ctrl`

## Requirements
- R1: While `rst` is sampled high, and after the first edge that samples it high, `hs_en_o` and `ls_en_o` are both 0. The controller is idle with both switches off.
- R2: A clock edge that samples `outen_i` = 0 leaves both enables at 0 after that edge, whatever PWM does. The controller returns to idle.
- R3: In phase with PWM, `hs_en_o` drops at the first edge that samples `pwm_i` = 0. `ls_en_o` drops at the first edge that samples `pwm_i` = 1.
- R4: Adaptive path. During the low-side wait, edges after the one where the high side dropped evaluate the wait. If an earlier evaluating edge sampled `sw_low_i` = 0, then `ls_en_o` rises at the first later edge that samples `sw_low_i` = 1.
- R5: Fallback path. The low-side wait starts at the edge where `hs_en_o` drops, or where the controller leaves idle with PWM low. If no evaluating edge has sampled `sw_low_i` = 0, then `ls_en_o` rises exactly FALLBACK_CYC edges after the wait starts.
- R6: Timeout path. If neither of the paths above has fired, `ls_en_o` rises exactly TIMEOUT_CYC edges after the wait starts, even with `sw_low_i` = 0.
- R7: During the high-side wait, `hs_en_o` rises exactly HS_ADD_CYC edges after the first edge that samples `gate_low_i` = 1, and never earlier.
- R8: `hs_en_o` and `ls_en_o` are never 1 in the same cycle. At least one cycle with both at 0 lies between one turning off and the other turning on.
- R9: If PWM reverses during a wait, the wait is abandoned. The controller starts the wait for the new PWM level with a fresh count and fresh observation flags, so even a one-cycle PWM pulse keeps both enables off until the new wait completes.
- R10: From idle, the first edge that samples `outen_i` = 1 starts the high-side wait if `pwm_i` = 1, or the low-side wait if `pwm_i` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_i | input | 1 | PWM command, 1 requests the high side |
| outen_i | input | 1 | Output enable, 0 forces both switches off |
| sw_low_i | input | 1 | Switch node below the low threshold |
| gate_low_i | input | 1 | Low-side gate below one sixth of its supply |
| hs_en_o | output | 1 | High-side gate enable (registered) |
| ls_en_o | output | 1 | Low-side gate enable (registered) |

## Verification
The bound checker checks several properties on every cycle. These are the absence of overlap with its one-cycle gap, the forced-off response to output enable, the one-edge turn-off when PWM opposes an enable, the reset state, and the PWM level present at each turn-on. The exact dead-time lengths cannot be shown by a per-cycle property. These are the adaptive, fallback and timeout paths to the low side, the feedback-plus-delay path to the high side, and the fresh restart after a reversal. The bench scenarios show them, measuring edges from the start of each wait and comparing every cycle with a reference model.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [2:0] {
    DT_IDLE    = 3'd0,
    DT_HI_ON   = 3'd1,
    DT_LO_WAIT = 3'd2,
    DT_LO_ON   = 3'd3,
    DT_HI_WAIT = 3'd4
  } dt_state_e;
endpackage

// File: rtl/dtc_wait_cnt.sv
module dtc_wait_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/dtc_flag.sv
module dtc_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst || clr) flag <= 1'b0;
    else if (set)   flag <= 1'b1;
  end
endmodule

// File: rtl/deadtime_gate_ctrl.sv
module deadtime_gate_ctrl #(
  parameter int FALLBACK_CYC = 15,
  parameter int TIMEOUT_CYC  = 19,
  parameter int HS_ADD_CYC   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_i,
  input  logic outen_i,
  input  logic sw_low_i,
  input  logic gate_low_i,
  output logic hs_en_o,
  output logic ls_en_o
);
  import dtc_pkg::*;

  localparam int MAX_A = (FALLBACK_CYC > TIMEOUT_CYC) ? FALLBACK_CYC : TIMEOUT_CYC;
  localparam int MAX_C = (MAX_A > HS_ADD_CYC) ? MAX_A : HS_ADD_CYC;
  localparam int CW    = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] FB_LAST  = CW'(FALLBACK_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] ADD_LAST = CW'(HS_ADD_CYC - 1);

  dt_state_e st, nxt;
  logic [CW-1:0] cnt;
  logic clr, inc, node_seen, gate_ok, seen_set, ok_set;
  logic lo_adapt, lo_fallback, lo_timeout;

  dtc_wait_cnt #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr), .inc(inc), .count(cnt)
  );

  // node observed high during the low-side wait
  dtc_flag u_seen (
    .clk(clk), .rst(rst), .clr(clr), .set(seen_set), .flag(node_seen)
  );

  // low-side gate reported low during the high-side wait
  dtc_flag u_gok (
    .clk(clk), .rst(rst), .clr(clr), .set(ok_set), .flag(gate_ok)
  );

  assign seen_set    = (st == DT_LO_WAIT) && !sw_low_i;
  assign lo_adapt    = node_seen && sw_low_i;
  assign lo_fallback = !node_seen && sw_low_i && (cnt == FB_LAST);
  assign lo_timeout  = (cnt == TMO_LAST);

  always_comb begin
    nxt    = st;
    clr    = 1'b0;
    inc    = 1'b0;
    ok_set = 1'b0;
    case (st)
      DT_IDLE: begin
        nxt = pwm_i ? DT_HI_WAIT : DT_LO_WAIT;
        clr = 1'b1;
      end
      DT_HI_ON: begin
        if (!pwm_i) begin
          nxt = DT_LO_WAIT;
          clr = 1'b1;
        end
      end
      DT_LO_WAIT: begin
        if (pwm_i) begin
          nxt = DT_HI_WAIT;
          clr = 1'b1;
        end else if (lo_adapt || lo_fallback || lo_timeout) begin
          nxt = DT_LO_ON;
        end else begin
          inc = 1'b1;
        end
      end
      DT_LO_ON: begin
        if (pwm_i) begin
          nxt = DT_HI_WAIT;
          clr = 1'b1;
        end
      end
      DT_HI_WAIT: begin
        if (!pwm_i) begin
          nxt = DT_LO_WAIT;
          clr = 1'b1;
        end else if (gate_ok) begin
          if (cnt == ADD_LAST) nxt = DT_HI_ON;
          else                 inc = 1'b1;
        end else if (gate_low_i) begin
          ok_set = 1'b1;
        end
      end
      default: begin
        nxt = DT_IDLE;
        clr = 1'b1;
      end
    endcase
    if (!outen_i) begin
      nxt    = DT_IDLE;
      clr    = 1'b1;
      inc    = 1'b0;
      ok_set = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= DT_IDLE;
      hs_en_o <= 1'b0;
      ls_en_o <= 1'b0;
    end else begin
      st      <= nxt;
      hs_en_o <= (nxt == DT_HI_ON);
      ls_en_o <= (nxt == DT_LO_ON);
    end
  end
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker (
  input logic clk,
  input logic rst,
  input logic pwm,
  input logic outen,
  input logic hs,
  input logic ls
);
  assert_reset_off_R1: assert property (@(posedge clk) rst |=> (!hs && !ls));

  assert_disable_off_R2: assert property (@(posedge clk) disable iff (rst)
    !outen |=> (!hs && !ls));

  assert_hs_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (hs && !pwm) |=> !hs);

  assert_ls_follow_R3: assert property (@(posedge clk) disable iff (rst)
    (ls && pwm) |=> !ls);

  assert_ls_rise_pwm_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ls) |-> (!$past(pwm) && $past(outen)));

  assert_hs_rise_pwm_high_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(hs) |-> ($past(pwm) && $past(outen)));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (rst)
    !(hs && ls));

  assert_gap_hs_ls_R8: assert property (@(posedge clk) disable iff (rst)
    hs |=> !ls);

  assert_gap_ls_hs_R8: assert property (@(posedge clk) disable iff (rst)
    ls |=> !hs);
endmodule

bind deadtime_gate_ctrl dtc_checker u_chk (
  .clk(clk), .rst(rst), .pwm(pwm_i), .outen(outen_i), .hs(hs_en_o), .ls(ls_en_o)
);

// File: tb/deadtime_gate_ctrl_test.sv
module deadtime_gate_ctrl_test;
  localparam int FALL = 15;
  localparam int TMO  = 19;
  localparam int ADD  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm = 1'b0, outen = 1'b0, swl = 1'b1, gl = 1'b1;
  logic hs, ls;

  always #4 clk = ~clk;

  deadtime_gate_ctrl #(.FALLBACK_CYC(FALL), .TIMEOUT_CYC(TMO), .HS_ADD_CYC(ADD)) uut (
    .clk(clk), .rst(rst), .pwm_i(pwm), .outen_i(outen), .sw_low_i(swl),
    .gate_low_i(gl), .hs_en_o(hs), .ls_en_o(ls)
  );

  int tests = 0, fails = 0;
  string tag = "R1";

  // reference model: 0 idle, 1 high on, 2 low wait, 3 low on, 4 high wait
  int m_st = 0, m_cnt = 0;
  bit m_seen = 0, m_ok = 0, m_hs = 0, m_ls = 0;

  task automatic m_restart(input int s);
    m_st = s; m_cnt = 0; m_seen = 0; m_ok = 0;
  endtask

  always @(posedge clk) begin
    if (rst || !outen) m_restart(0);
    else begin
      case (m_st)
        0: m_restart(pwm ? 4 : 2);
        1: if (!pwm) m_restart(2);
        2: begin
          if (pwm) m_restart(4);
          else if ((m_seen && swl) || (!m_seen && swl && m_cnt == FALL-1) || m_cnt == TMO-1)
            m_st = 3;
          else begin
            m_cnt++;
            if (!swl) m_seen = 1;
          end
        end
        3: if (pwm) m_restart(4);
        default: begin
          if (!pwm) m_restart(2);
          else if (m_ok) begin
            if (m_cnt == ADD-1) m_st = 1;
            else m_cnt++;
          end else if (gl) m_ok = 1;
        end
      endcase
    end
    m_hs = (m_st == 1);
    m_ls = (m_st == 3);
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(tag, "hs vs model", hs, m_hs);
    check(tag, "ls vs model", ls, m_ls);
    check("R8", "no overlap", hs & ls, 1'b0);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) step();
    check("R1", "hs in reset", hs, 1'b0);
    check("R1", "ls in reset", ls, 1'b0);
    rst = 1'b0;
    tag = "R2";
    repeat (3) step();
    check("R2", "idle hs while disabled", hs, 1'b0);

    // R10 + R5: leave idle with PWM low, node never high
    tag = "R10"; outen = 1'b1; pwm = 1'b0; swl = 1'b1;
    repeat (FALL) step();
    check("R10", "ls before fallback", ls, 1'b0);
    step();
    check("R10", "ls at fallback from idle", ls, 1'b1);

    // R7: high-side wait gated on gate feedback
    tag = "R7"; pwm = 1'b1; gl = 1'b0;
    step();
    check("R3", "ls drops on pwm high", ls, 1'b0);
    repeat (2) step();
    check("R7", "hs held without feedback", hs, 1'b0);
    gl = 1'b1;
    repeat (ADD) step();
    check("R7", "hs before added delay", hs, 1'b0);
    step();
    check("R7", "hs after added delay", hs, 1'b1);

    // R4: adaptive path
    tag = "R4"; pwm = 1'b0; swl = 1'b0;
    step();
    check("R3", "hs drops on pwm low", hs, 1'b0);
    repeat (5) step();
    check("R4", "ls held while node high", ls, 1'b0);
    swl = 1'b1;
    step();
    check("R4", "ls on node fall", ls, 1'b1);

    // back to high side
    tag = "R7"; pwm = 1'b1; gl = 1'b1;
    repeat (ADD + 1) step();
    check("R7", "hs before delay", hs, 1'b0);
    step();
    check("R7", "hs on", hs, 1'b1);

    // R6: timeout path
    tag = "R6"; pwm = 1'b0; swl = 1'b0;
    repeat (TMO) step();
    check("R6", "ls before timeout", ls, 1'b0);
    step();
    check("R6", "ls at timeout", ls, 1'b1);

    tag = "R7"; pwm = 1'b1;
    repeat (ADD + 2) step();
    check("R7", "hs on again", hs, 1'b1);

    // R5: fallback path from high side on
    tag = "R5"; pwm = 1'b0; swl = 1'b1;
    repeat (FALL) step();
    check("R5", "ls before fallback", ls, 1'b0);
    step();
    check("R5", "ls at fallback", ls, 1'b1);

    tag = "R7"; pwm = 1'b1;
    repeat (ADD + 2) step();
    check("R7", "hs on before disable", hs, 1'b1);

    // R2: disable mid-cycle, PWM activity ignored
    tag = "R2"; outen = 1'b0;
    step();
    check("R2", "hs forced off", hs, 1'b0);
    check("R2", "ls forced off", ls, 1'b0);
    pwm = 1'b0;
    repeat (4) step();
    check("R2", "ls stays off while disabled", ls, 1'b0);
    pwm = 1'b1;
    step();
    check("R2", "hs stays off while disabled", hs, 1'b0);
    pwm = 1'b0; outen = 1'b1;
    repeat (FALL + 1) step();
    check("R5", "ls on after re-enable", ls, 1'b1);

    // R9: reversal restarts the wait with fresh state
    tag = "R9"; pwm = 1'b1; gl = 1'b1;
    step();
    step();
    pwm = 1'b0;
    step();
    check("R9", "hs off after reversal", hs, 1'b0);
    check("R9", "ls off after reversal", ls, 1'b0);
    pwm = 1'b1;
    step();
    repeat (ADD) step();
    check("R9", "hs waits fresh count", hs, 1'b0);
    step();
    check("R9", "hs on after fresh wait", hs, 1'b1);

    // R9: very narrow pulses
    for (int i = 0; i < 12; i++) begin
      pwm = ~pwm;
      step();
    end
    check("R9", "hs off during narrow pulses", hs, 1'b0);
    check("R9", "ls off during narrow pulses", ls, 1'b0);

    // R8: constrained random mix
    tag = "R8";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 23 == 0) pwm = ~pwm;
      if (!outen) outen = ($urandom % 4 != 0);
      else        outen = ($urandom % 211 != 0);
      swl = ($urandom % 3 != 0);
      gl  = ($urandom % 2 == 0);
      step();
    end

    finish_run();
  end
endmodule